// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block holds one configuration word for each of four memory banks and turns every word into a base address, a size and an enable. It takes an incoming 32-bit physical address and reports whether an active bank covers it. On a hit it also reports the number of the bank that matched and the byte offset into that bank. The address lookup is purely combinational, so a memory controller can use the result in the cycle in which it presents the address.

Configuration words are written through a single write port that carries a bank index, and they can be read back through a combinational read port. A bank takes part in decoding only when its own enable bit is set and the controller-wide enable input is high. Dropping the controller enable unmaps every bank at once, and the stored words are kept.

Top module: `bank_addr_decoder`

## Requirements
- R1: After reset all four configuration words read back as zero. No address hits, `lk_miss` is 1, and `lk_bank` and `lk_offset` are zero.
- R2: A written word is stored ANDed with 0xFFDEE001. Every other bit reads back as zero on `cfg_rdata` for the bank chosen by `cfg_ridx`.
- R3: The bank base is bits 31:23 of the word, with the low 23 bits zero. An address hits when base <= address < base + size. The window may reach the top of the 32-bit space without wrapping.
- R4: The size code is bits 19:17 of the word. Codes 0 to 6 give a size of 4 MiB shifted left by the code, that is 4 MiB to 256 MiB.
- R5: A bank with size code 7 never produces a hit.
- R6: Bit 0 of the word is the bank enable. A bank whose bit 0 is clear never hits.
- R7: While `ctl_enable` is low no bank hits. The lookup follows `ctl_enable` in the same cycle, and the stored words are unaffected.
- R8: When several active banks cover the address, the bank with the lowest index is reported.
- R9: On a hit, `lk_offset` equals the address minus the winning bank's base and `lk_bank` is its index. `lk_miss` is the inverse of `lk_hit`. On a miss, `lk_bank` and `lk_offset` are zero.
- R10: A write takes effect on the clock edge where `cfg_we` is high. A lookup in the same cycle as the write still uses the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller-wide mapping enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_widx | input | 2 | Bank index for the write |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_ridx | input | 2 | Bank index for readback |
| cfg_rdata | output | 32 | Stored (masked) word of bank `cfg_ridx` |
| lk_addr | input | 32 | Physical address to decode |
| lk_hit | output | 1 | Some active bank covers `lk_addr` |
| lk_miss | output | 1 | No active bank covers `lk_addr` |
| lk_bank | output | 2 | Index of the winning bank |
| lk_offset | output | 32 | `lk_addr` minus the winning bank's base |

## Verification
A configuration write and an address lookup can fall in the same cycle. A lookup then has to reflect the old word up to the edge and the new word after it. The bench provokes this by setting up a lookup address inside bank 0's current window and then writing bank 0 with a different base while keeping that address. It samples the outputs just before the edge, where the old mapping must still hit, and again just after it, where the address must fall outside the new window. Changes of `ctl_enable` are judged the same way, within the cycle in which they happen.

// File: rtl/bankdec_pkg.sv
package bankdec_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam logic [31:0] CFG_MASK   = 32'hFFDE_E001;
    localparam logic [31:0] BASE_MASK  = 32'hFF80_0000;
    localparam int unsigned CODE_LSB   = 17;
    localparam int unsigned CODE_W     = 3;
    localparam logic [2:0]  CODE_RSVD  = 3'd7;
    localparam logic [31:0] UNIT_SIZE  = 32'h0040_0000;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] size;
        logic        bank_on;
        logic        code_ok;
    } bank_dec_t;

    function automatic bank_dec_t decode_word(input logic [31:0] w);
        bank_dec_t d;
        logic [CODE_W-1:0] code;
        code      = w[CODE_LSB +: CODE_W];
        d.base    = w & BASE_MASK;
        d.code_ok = (code != CODE_RSVD);
        d.size    = d.code_ok ? (UNIT_SIZE << code) : 32'd0;
        d.bank_on = w[0];
        return d;
    endfunction

endpackage

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
    import bankdec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [IDX_W-1:0]                widx,
    input  logic [31:0]                     wdata,
    input  logic [IDX_W-1:0]                ridx,
    output logic [31:0]                     rdata,
    output logic [NUM_BANKS-1:0][31:0]      words
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][31:0] word;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (32'(widx) < NUM_BANKS)) begin
            regs_d.word[widx] = wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign words = regs_q.word;
    assign rdata = (32'(ridx) < NUM_BANKS) ? regs_q.word[ridx] : 32'd0;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
        // R10: the written word (masked) is present one edge later
        p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (we && widx == IDX_W'(g)) |=> (words[g] == ($past(wdata) & CFG_MASK)));
        // R2: bits outside the kept mask never become set
        p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (words[g] & ~CFG_MASK) == 32'd0);
    end

endmodule

// File: rtl/bank_window.sv
module bank_window
    import bankdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] word,
    input  logic        ctl_enable,
    input  logic [31:0] addr,
    output logic        in_range,
    output logic [31:0] offset
);

    bank_dec_t   dec;
    logic [32:0] diff;
    logic        above_base;
    logic        below_top;

    always_comb begin
        dec        = decode_word(word);
        diff       = {1'b0, addr} - {1'b0, dec.base};
        above_base = ~diff[32];
        below_top  = (diff[31:0] < dec.size);
        in_range   = ctl_enable && dec.bank_on && dec.code_ok && above_base && below_top;
        offset     = diff[31:0];
    end

    // R5: reserved size code blocks every hit
    p_reserved_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word[19:17] == 3'd7) |-> !in_range);
    // R6: bank with enable bit clear is silent
    p_bank_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word[0] |-> !in_range);

endmodule

// File: rtl/bank_hit_select.sv
module bank_hit_select #(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS-1:0]        in_range,
    input  logic [NUM_BANKS-1:0][31:0]  offsets,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx,
    output logic [31:0]                 offset
);

    logic [NUM_BANKS-1:0] grant;

    always_comb begin
        grant  = '0;
        hit    = 1'b0;
        idx    = '0;
        offset = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                hit    = 1'b1;
                idx    = IDX_W'(i);
                offset = offsets[i];
            end
        end
    end

    // R8: at most one bank is granted
    p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8: no lower-numbered bank was also in range
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((in_range & ((NUM_BANKS'(1) << idx) - NUM_BANKS'(1))) == '0));

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
    import bankdec_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_widx,
    input  logic [31:0]      cfg_wdata,
    input  logic [IDX_W-1:0] cfg_ridx,
    output logic [31:0]      cfg_rdata,
    input  logic [31:0]      lk_addr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [IDX_W-1:0] lk_bank,
    output logic [31:0]      lk_offset
);

    logic [NUM_BANKS-1:0][31:0] words;
    logic [NUM_BANKS-1:0]       in_range;
    logic [NUM_BANKS-1:0][31:0] offsets;

    bank_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .widx  (cfg_widx),
        .wdata (cfg_wdata),
        .ridx  (cfg_ridx),
        .rdata (cfg_rdata),
        .words (words)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
        bank_window u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .word       (words[b]),
            .ctl_enable (ctl_enable),
            .addr       (lk_addr),
            .in_range   (in_range[b]),
            .offset     (offsets[b])
        );
    end

    bank_hit_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_range (in_range),
        .offsets  (offsets),
        .hit      (lk_hit),
        .idx      (lk_bank),
        .offset   (lk_offset)
    );

    assign lk_miss = ~lk_hit;

    // R9: hit and miss are exclusive and complete
    p_hit_xor_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit != lk_miss);
    // R7: no mapping survives a low controller enable
    p_ctl_off_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |-> lk_miss);
    // R3: a reported hit lies at or above the winning base
    p_hit_above_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_addr >= (words[lk_bank] & BASE_MASK)));
    // R9: a miss reports index and offset zero
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_bank == '0 && lk_offset == 32'd0));

endmodule

// File: tb/tb_bank_addr_decoder.sv
module tb_bank_addr_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_widx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_hit, lk_miss;
    logic [1:0]  lk_bank;
    logic [31:0] lk_offset;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
        .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
        .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_bank(lk_bank), .lk_offset(lk_offset)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_widx = idx; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic h,
                        input logic [1:0] b, input logic [31:0] off);
        lk_addr = a;
        #1;
        check({req, " hit"}, 32'(lk_hit), 32'(h));
        check({req, " miss"}, 32'(lk_miss), 32'(!h));
        check({req, " bank"}, 32'(lk_bank), h ? 32'(b) : 32'd0);
        check({req, " offset"}, lk_offset, h ? off : 32'd0);
    endtask

    function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit en);
        return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(en);
    endfunction

    task automatic clear_all();
        for (int i = 0; i < 4; i++) wr(2'(i), 32'd0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            cfg_ridx = 2'(i); #1;
            check("R1 reset word", cfg_rdata, 32'd0);
        end
        ctl_enable = 1'b1;
        look("R1 reset lookup", 32'h0000_0000, 1'b0, 2'd0, 32'd0);
    endtask

    task automatic t_readback();
        wr(2'd2, 32'hFFFF_FFFF);
        cfg_ridx = 2'd2; #1;
        check("R2 mask all-ones", cfg_rdata, 32'hFFDE_E001);
        wr(2'd2, 32'h0021_1FFE);
        #1;
        check("R2 dropped bits", cfg_rdata, 32'd0);
        clear_all();
    endtask

    task automatic t_sizes();
        for (int c = 0; c <= 6; c++) begin
            logic [31:0] sz;
            sz = 32'h0040_0000 << c;
            wr(2'd0, mk(32'h1000_0000, c, 1'b1));
            look("R4 first byte", 32'h1000_0000, 1'b1, 2'd0, 32'd0);
            look("R4 last byte", 32'h1000_0000 + sz - 1, 1'b1, 2'd0, sz - 1);
            look("R3 past end", 32'h1000_0000 + sz, 1'b0, 2'd0, 32'd0);
            look("R3 below base", 32'h0FFF_FFFF, 1'b0, 2'd0, 32'd0);
        end
        wr(2'd0, mk(32'hF000_0000, 6, 1'b1));
        look("R3 top of space", 32'hFFFF_FFFF, 1'b1, 2'd0, 32'h0FFF_FFFF);
        wr(2'd0, mk(32'hFF80_0000, 0, 1'b1));
        look("R3 high base", 32'hFF80_0004, 1'b1, 2'd0, 32'h4);
        look("R3 high base below", 32'hFF7F_FFFF, 1'b0, 2'd0, 32'd0);
        clear_all();
    endtask

    task automatic t_reserved_and_enable();
        wr(2'd3, mk(32'h4000_0000, 7, 1'b1));
        look("R5 reserved code", 32'h4000_0000, 1'b0, 2'd0, 32'd0);
        wr(2'd1, mk(32'h2000_0000, 3, 1'b0));
        look("R6 bank bit clear", 32'h2000_0100, 1'b0, 2'd0, 32'd0);
        wr(2'd1, mk(32'h2000_0000, 3, 1'b1));
        look("R6 bank bit set", 32'h2000_0100, 1'b1, 2'd1, 32'h100);
        clear_all();
    endtask

    task automatic t_ctl_enable();
        wr(2'd2, mk(32'h0800_0000, 1, 1'b1));
        look("R7 enabled", 32'h0800_0010, 1'b1, 2'd2, 32'h10);
        ctl_enable = 1'b0;
        look("R7 ctl low", 32'h0800_0010, 1'b0, 2'd0, 32'd0);
        cfg_ridx = 2'd2; #1;
        check("R7 word kept", cfg_rdata, mk(32'h0800_0000, 1, 1'b1));
        ctl_enable = 1'b1;
        look("R7 ctl back", 32'h0800_0010, 1'b1, 2'd2, 32'h10);
        clear_all();
    endtask

    task automatic t_overlap();
        wr(2'd1, mk(32'h0000_0000, 2, 1'b1));
        wr(2'd2, mk(32'h0080_0000, 0, 1'b1));
        look("R8 lowest wins", 32'h0090_0000, 1'b1, 2'd1, 32'h0090_0000);
        look("R9 only bank1", 32'h0000_0040, 1'b1, 2'd1, 32'h40);
        wr(2'd1, 32'd0);
        look("R8 next bank", 32'h0090_0000, 1'b1, 2'd2, 32'h0010_0000);
        clear_all();
    endtask

    task automatic t_same_cycle();
        wr(2'd0, mk(32'h3000_0000, 0, 1'b1));
        @(negedge clk);
        lk_addr = 32'h3000_0020;
        cfg_we = 1'b1; cfg_widx = 2'd0; cfg_wdata = mk(32'h5000_0000, 0, 1'b1);
        #1;
        check("R10 old word before edge", 32'(lk_hit), 32'd1);
        check("R10 old offset", lk_offset, 32'h20);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        check("R10 new word after edge", 32'(lk_hit), 32'd0);
        look("R10 new window", 32'h5000_0020, 1'b1, 2'd0, 32'h20);
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readback();
        t_sizes();
        t_reserved_and_enable();
        t_ctl_enable();
        t_overlap();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule